// File: doc/BRIEF.md
# Multi-Queue Write Port Selector

This block is the write side of a multi-queue FIFO. It holds a set of independent queues, four by default, of 18-bit words. A write-address bus picks the queue that receives data. The low address bits give the queue index. The high address bits name one of up to eight devices that share the bus, and only a device whose configured ID matches takes the selection. Another device's ID deselects this one. The address is captured on a clock edge while the address-enable strobe is high. Selection is pipelined: after a capture, the previously selected queue still accepts writes on the capture edge and on the edge after it. The new queue takes data from the second edge after the capture onward.

Words are written by holding the active-low write enable low. The write interface has no ready signal. Back-pressure is the full flag, which reports whether the queue currently selected for writing is full. A write into a full queue is dropped. The source must watch the full flag and stop writing while it is high. A plain per-queue pop port lets a test environment drain and inspect the queues. Two misuses of the strobe are ignored and latch a sticky error bit: raising address enable in the same cycle as the flag-select strobe, and raising it before programming is done.

Top module: `mq_write_port`

## Requirements
- R1: `wr_addr[4:2]` is a device ID and `wr_addr[1:0]` is a queue index. A capture whose ID differs from parameter `DEV_ID` (default 5) leaves no queue of this device selected. From then on, writes are dropped and `full_o` is 0.
- R2: A capture happens on a rising edge with `addr_en`=1. It does not depend on `wr_en_n`.
- R3: A write with `wr_en_n`=0 on the capture edge, or on the edge right after it, goes into the previously selected queue.
- R4: Writes from the second edge after a capture onward go into the newly selected queue.
- R5: A write stores `wr_data` into the selected queue. Words leave each queue in the order they were written.
- R6: A write into a queue that holds `DEPTH` words (default 16) is dropped. The queue's contents and count stay unchanged.
- R7: After each edge, `full_o` is 1 exactly when a queue is selected and that queue holds `DEPTH` words. After a capture, `full_o` switches to the new queue once the edge after the capture has passed.
- R8: `addr_en`=1 together with `flag_sel`=1, or together with `prog_done`=0, captures nothing. It sets `err_o` after that edge, and `err_o` stays 1 until reset.
- R9: After reset, no queue is selected, every queue is empty, and `full_o` and `err_o` are 0.
- R10: `rd_data` shows the oldest word of queue `rd_q`, and `rd_empty` is 1 when that queue is empty. `rd_pop`=1 removes the oldest word on the edge. A pop of an empty queue does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_en | input | 1 | Address-enable strobe for queue selection |
| wr_addr | input | 5 | Device ID [4:2] and queue index [1:0] |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 18 | Write data |
| flag_sel | input | 1 | Flag-select strobe; must not coincide with addr_en |
| prog_done | input | 1 | High once device programming has finished |
| full_o | output | 1 | Selected queue is full |
| err_o | output | 1 | Sticky strobe-misuse error |
| rd_q | input | 2 | Queue index for the pop port |
| rd_pop | input | 1 | Pop the oldest word of queue rd_q |
| rd_data | output | 18 | Oldest word of queue rd_q |
| rd_empty | output | 1 | Queue rd_q is empty |

## Verification
A capture on edge N decides where writes go from edge N+2 onward, and `full_o` follows the new queue from edge N+1 onward. A write or pop on edge N changes `rd_data`, `rd_empty` and `full_o` right after edge N, and a misuse on edge N raises `err_o` right after edge N. The bench drives inputs just after a falling edge and advances its own model by one edge per drive. It compares each output at the following falling edge, so every result is read exactly one edge after the stimulus that caused it. The directed sequences count the edges from a capture explicitly to check the two-edge switch-over.

// File: rtl/mq_pkg.sv
package mq_pkg;
  typedef enum logic [1:0] {
    VIOL_NONE   = 2'd0,
    VIOL_STROBE = 2'd1,
    VIOL_NOPROG = 2'd2
  } mq_viol_e;
endpackage

// File: rtl/mq_sel_pipe.sv
module mq_sel_pipe
  import mq_pkg::*;
#(
  parameter int QW     = 2,
  parameter int DEV_W  = 3,
  parameter int DEV_ID = 5,
  localparam int ADDR_W = QW + DEV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              flag_sel,
  input  logic              prog_done,
  output logic              sel_valid,
  output logic [QW-1:0]     sel_q,
  output logic              err
);
  mq_viol_e      viol;
  logic          take;
  logic          id_hit;
  logic          pend_v;
  logic          pend_hit;
  logic [QW-1:0] pend_q;

  always_comb begin
    viol = VIOL_NONE;
    if (addr_en && flag_sel)        viol = VIOL_STROBE;
    else if (addr_en && !prog_done) viol = VIOL_NOPROG;
  end

  assign take   = addr_en && (viol == VIOL_NONE);
  assign id_hit = (wr_addr[ADDR_W-1:QW] == DEV_W'(DEV_ID));

  // stage 1: captured address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_hit <= 1'b0;
      pend_q   <= '0;
    end else begin
      pend_v <= take;
      if (take) begin
        pend_hit <= id_hit;
        pend_q   <= wr_addr[QW-1:0];
      end
    end
  end

  // stage 2: selection in effect for writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_q     <= '0;
    end else if (pend_v) begin
      sel_valid <= pend_hit;
      sel_q     <= pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 err <= 1'b0;
    else if (viol != VIOL_NONE) err <= 1'b1;
  end
endmodule

// File: rtl/mq_queue.sv
module mq_queue #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wptr;
  logic [PW-1:0]     rptr;
  logic              do_push;
  logic              do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mq_route.sv
module mq_route #(
  parameter int NUM_Q = 4,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic             sel_valid,
  input  logic [QW-1:0]    sel_q,
  input  logic             wr_en_n,
  input  logic [NUM_Q-1:0] q_full,
  output logic [NUM_Q-1:0] q_push,
  output logic             full_o
);
  for (genvar i = 0; i < NUM_Q; i++) begin : g_dec
    assign q_push[i] = sel_valid && !wr_en_n && (sel_q == QW'(i));
  end

  assign full_o = sel_valid && q_full[sel_q];
endmodule

// File: rtl/mq_write_port.sv
module mq_write_port #(
  parameter int DATA_W = 18,
  parameter int NUM_Q  = 4,
  parameter int DEPTH  = 16,
  parameter int DEV_W  = 3,
  parameter int DEV_ID = 5,
  localparam int QW     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int ADDR_W = QW + DEV_W,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flag_sel,
  input  logic              prog_done,
  output logic              full_o,
  output logic              err_o,
  input  logic [QW-1:0]     rd_q,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  logic              sel_valid;
  logic [QW-1:0]     sel_q;
  logic [NUM_Q-1:0]  q_push;
  logic [NUM_Q-1:0]  q_pop;
  logic [NUM_Q-1:0]  q_full;
  logic [NUM_Q-1:0]  q_empty;
  logic [DATA_W-1:0] q_head [NUM_Q];
  logic [CW-1:0]     q_cnt  [NUM_Q];

  mq_sel_pipe #(.QW(QW), .DEV_W(DEV_W), .DEV_ID(DEV_ID)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_en   (addr_en),
    .wr_addr   (wr_addr),
    .flag_sel  (flag_sel),
    .prog_done (prog_done),
    .sel_valid (sel_valid),
    .sel_q     (sel_q),
    .err       (err_o)
  );

  mq_route #(.NUM_Q(NUM_Q)) u_route (
    .sel_valid (sel_valid),
    .sel_q     (sel_q),
    .wr_en_n   (wr_en_n),
    .q_full    (q_full),
    .q_push    (q_push),
    .full_o    (full_o)
  );

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    assign q_pop[i] = rd_pop && (rd_q == QW'(i));
    mq_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push[i]),
      .pop   (q_pop[i]),
      .din   (wr_data),
      .head  (q_head[i]),
      .count (q_cnt[i]),
      .full  (q_full[i]),
      .empty (q_empty[i])
    );
  end

  assign rd_data  = q_head[rd_q];
  assign rd_empty = q_empty[rd_q];
endmodule

// File: rtl/mq_write_port_chk.sv
module mq_write_port_chk #(
  parameter int NUM_Q  = 4,
  parameter int DEPTH  = 16,
  parameter int DEV_W  = 3,
  parameter int DEV_ID = 5,
  localparam int QW     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int ADDR_W = QW + DEV_W,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              flag_sel,
  input logic              prog_done,
  input logic              rd_pop,
  input logic [QW-1:0]     rd_q,
  input logic              full_o,
  input logic              err_o,
  input logic              sel_valid,
  input logic [QW-1:0]     sel_q,
  input logic [NUM_Q-1:0]  q_push,
  input logic [CW-1:0]     q_cnt [NUM_Q]
);
  logic good_cap;
  assign good_cap = addr_en && prog_done && !flag_sel;

  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en && (flag_sel || !prog_done) |=> err_o);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  p_sel_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    good_cap && (wr_addr[ADDR_W-1:QW] == DEV_W'(DEV_ID))
    |=> ##1 (sel_valid && (sel_q == $past(wr_addr[QW-1:0], 2))));

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    good_cap && (wr_addr[ADDR_W-1:QW] != DEV_W'(DEV_ID)) |=> ##1 !full_o);

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt[i] <= CW'(DEPTH));

    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (q_cnt[i] == CW'(DEPTH)) && !(rd_pop && rd_q == QW'(i)) |=> q_cnt[i] == CW'(DEPTH));

    p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (q_cnt[i] == '0) && !q_push[i] |=> q_cnt[i] == '0);
  end
endmodule

bind mq_write_port mq_write_port_chk #(
  .NUM_Q(NUM_Q), .DEPTH(DEPTH), .DEV_W(DEV_W), .DEV_ID(DEV_ID)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_en   (addr_en),
  .wr_addr   (wr_addr),
  .flag_sel  (flag_sel),
  .prog_done (prog_done),
  .rd_pop    (rd_pop),
  .rd_q      (rd_q),
  .full_o    (full_o),
  .err_o     (err_o),
  .sel_valid (sel_valid),
  .sel_q     (sel_q),
  .q_push    (q_push),
  .q_cnt     (q_cnt)
);

// File: tb/mq_write_port_bench.sv
`timescale 1ns/1ps
module mq_write_port_bench;
  localparam int D  = 16;
  localparam int ID = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic        wr_en_n = 1'b1;
  logic [17:0] wr_data = '0;
  logic        flag_sel = 1'b0;
  logic        prog_done = 1'b0;
  logic [1:0]  rd_q = '0;
  logic        rd_pop = 1'b0;
  logic        full_o, err_o, rd_empty;
  logic [17:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  logic [17:0] m_mem [4][D];
  int          m_head [4];
  int          m_cnt  [4];
  bit          m_pv, m_ph, m_sv, m_err;
  int          m_pq, m_cq;

  always #4 clk = ~clk;

  mq_write_port u_mq_write_port (
    .clk(clk), .rst_n(rst_n), .addr_en(addr_en), .wr_addr(wr_addr),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .flag_sel(flag_sel),
    .prog_done(prog_done), .full_o(full_o), .err_o(err_o),
    .rd_q(rd_q), .rd_pop(rd_pop), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_full();
    return m_sv && (m_cnt[m_cq] == D);
  endfunction

  task automatic model_reset();
    for (int q = 0; q < 4; q++) begin m_head[q] = 0; m_cnt[q] = 0; end
    m_pv = 0; m_ph = 0; m_sv = 0; m_err = 0; m_pq = 0; m_cq = 0;
  endtask

  task automatic check_outputs();
    chk(32'(full_o), 32'(exp_full()), "R7 full_o");
    chk(32'(err_o), 32'(m_err), "R8 err_o");
    chk(32'(rd_empty), 32'(m_cnt[rd_q] == 0), "R10 rd_empty");
    if (m_cnt[rd_q] != 0)
      chk(32'(rd_data), 32'(m_mem[rd_q][m_head[rd_q]]), "R5 rd_data");
  endtask

  // one clock: check previous results, drive, advance model by one edge
  task automatic step(input bit ae, input logic [4:0] ad, input bit wn,
                      input logic [17:0] d, input bit fs, input bit pd,
                      input bit rp, input logic [1:0] rq);
    bit take, push, pop;
    int tail;
    @(negedge clk);
    check_outputs();
    addr_en = ae; wr_addr = ad; wr_en_n = wn; wr_data = d;
    flag_sel = fs; prog_done = pd; rd_pop = rp; rd_q = rq;
    take = ae && !fs && pd;
    push = m_sv && !wn && (m_cnt[m_cq] < D);
    pop  = rp && (m_cnt[rq] > 0);
    if (push) begin
      tail = (m_head[m_cq] + m_cnt[m_cq]) % D;
      m_mem[m_cq][tail] = d;
    end
    if (pop) m_head[rq] = (m_head[rq] + 1) % D;
    if (push) m_cnt[m_cq]++;
    if (pop)  m_cnt[rq]--;
    if (ae && (fs || !pd)) m_err = 1;
    if (m_pv) begin m_sv = m_ph; m_cq = m_pq; end
    m_pv = take;
    if (take) begin m_ph = (ad[4:2] == 3'(ID)); m_pq = int'(ad[1:0]); end
  endtask

  task automatic idle(input logic [1:0] rq);
    step(0, 5'd0, 1, 18'd0, 0, 1, 0, rq);
  endtask
  task automatic sel(input logic [2:0] dev, input logic [1:0] q, input bit wn, input logic [17:0] d);
    step(1, {dev, q}, wn, d, 0, 1, 0, 2'd0);
  endtask
  task automatic wr(input logic [17:0] d);
    step(0, 5'd0, 0, d, 0, 1, 0, 2'd0);
  endtask
  task automatic popq(input logic [1:0] q);
    step(0, 5'd0, 1, 18'd0, 0, 1, 1, q);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; addr_en = 0; wr_en_n = 1; rd_pop = 0; flag_sel = 0; prog_done = 0;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    chk(32'(full_o), 0, "R9 full_o after reset");
    chk(32'(err_o), 0, "R9 err_o after reset");
    for (int q = 0; q < 4; q++) begin
      rd_q = 2'(q); #1;
      chk(32'(rd_empty), 1, "R9 queue empty after reset");
    end
    rd_q = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    // R2: capture with write enable inactive, then write lands in q0
    sel(3'(ID), 2'd0, 1, 18'd0);
    idle(0);
    wr(18'h000AA);
    idle(0); #1;
    chk(32'(rd_empty), 0, "R2 q0 holds word");
    chk(32'(rd_data), 32'h000AA, "R2 q0 word");
    popq(0);

    // R3/R4: switch to q2 while writing every cycle
    sel(3'(ID), 2'd2, 0, 18'h00101);
    wr(18'h00102);
    wr(18'h00103);
    idle(0); #1;
    chk(32'(rd_data), 32'h00101, "R3 capture-edge word in old queue");
    popq(0);
    idle(0); #1;
    chk(32'(rd_data), 32'h00102, "R3 next-edge word in old queue");
    popq(0);
    idle(0); #1;
    chk(32'(rd_empty), 1, "R3 old queue got only two words");
    idle(2); #1;
    chk(32'(rd_data), 32'h00103, "R4 new queue word");
    popq(2);

    // R6/R7: fill q2
    for (int i = 0; i < D; i++) begin
      wr(18'h00200 + 18'(i));
      if (i == D - 2) begin
        idle(0); #1;
        chk(32'(full_o), 0, "R7 not full at DEPTH-1");
      end
    end
    idle(0); #1;
    chk(32'(full_o), 1, "R7 full at DEPTH");
    wr(18'h003FF);
    idle(0); #1;
    chk(32'(full_o), 1, "R6 still full after dropped write");
    // R7: flag follows new selection one edge after capture
    sel(3'(ID), 2'd1, 1, 18'd0);
    idle(0); #1;
    chk(32'(full_o), 1, "R7 flag still old queue after capture edge");
    idle(0); #1;
    chk(32'(full_o), 0, "R7 flag follows new queue");
    for (int i = 0; i < D; i++) begin
      idle(2); #1;
      chk(32'(rd_data), 32'h00200 + 32'(i), "R6 contents intact");
      popq(2);
    end
    idle(2); #1;
    chk(32'(rd_empty), 1, "R6 dropped word not stored");
    popq(2);
    idle(2); #1;
    chk(32'(rd_empty), 1, "R10 pop of empty queue ignored");

    // R1: other device selected
    sel(3'd2, 2'd1, 1, 18'd0);
    idle(0);
    wr(18'h00077);
    idle(1); #1;
    chk(32'(rd_empty), 1, "R1 write dropped after deselect");
    chk(32'(full_o), 0, "R1 full_o low when deselected");
    sel(3'(ID), 2'd3, 1, 18'd0);
    idle(0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      bit ae, wn, rp;
      logic [2:0] dv;
      ae = ($urandom % 8) == 0;
      dv = (($urandom % 4) == 0) ? 3'($urandom) : 3'(ID);
      wn = ($urandom % 2) == 0;
      rp = ($urandom % 5) < 2;
      step(ae, {dv, 2'($urandom)}, wn, 18'($urandom), 0, 1, rp, 2'($urandom));
    end
    for (int q = 0; q < 4; q++) begin
      while (m_cnt[q] > 0) popq(2'(q));
    end

    // R8: violations
    sel(3'(ID), 2'd0, 1, 18'd0);
    idle(0); idle(0); #1;
    chk(32'(err_o), 0, "R8 no error before misuse");
    step(1, {3'(ID), 2'd1}, 1, 18'd0, 1, 1, 0, 2'd0);
    idle(0); #1;
    chk(32'(err_o), 1, "R8 error on strobe clash");
    idle(0);
    wr(18'h00055);
    idle(0); #1;
    chk(32'(rd_data), 32'h00055, "R8 clashing capture ignored");
    popq(0);
    step(1, {3'(ID), 2'd2}, 1, 18'd0, 0, 0, 0, 2'd0);
    idle(0); idle(0);
    wr(18'h00066);
    idle(0); #1;
    chk(32'(rd_data), 32'h00066, "R8 capture before programming ignored");
    chk(32'(err_o), 1, "R8 error sticky");
    popq(0);
    idle(0);
    @(negedge clk);
    check_outputs();

    // R9: reset clears sticky error
    do_reset();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule